// File: doc/BRIEF.md
# Serial Audio Port Interrupt Status Register

This block is the interrupt status word of a synchronous serial audio port that carries two transmit and two receive data channels. The datapath feeds it level conditions (FIFO full, FIFO empty, data ready, data empty) and one-cycle event pulses (overrun, underrun, frame sync, last time slot, AC97 command and tag updates). It shows all of them in one 32-bit word that software can read. A 19-bit enable word masks the flags into a single interrupt line.

Flags do not move on every clock. The serial shifter raises `word_commit` once the first bit of each new serial word has shifted in or out. Events that arrive during a word are held inside the block and published at that strobe, and level flags are sampled from their sources at the same moment. Nothing is updated while the port is disabled. Overrun and underrun flags need a two-step clear: software reads the status word, then accesses the data register of the channel concerned. The frame, slot and AC97 flags clear when the status word is read.

Top module: `sai_irq_status`

## Requirements
- R1: Bit positions of the status word (`reg_addr`=0): 18 command-address update, 17 command-data update, 16 receive-tag update, 15/14 receive data ready ch1/ch0, 13/12 transmit data empty ch1/ch0, 11/10 receive overrun ch1/ch0, 9/8 transmit underrun ch1/ch0, 7 transmit frame sync, 6 receive frame sync, 5 transmit last slot, 4 receive last slot, 3/2 receive FIFO full ch1/ch0, 1/0 transmit FIFO empty ch1/ch0. Bits 31..19 read as zero.
- R2: After reset the status word reads 0x0000_3003 and the enable word reads 0.
- R3: While `port_en` is low, event pulses are discarded and no level or event flag changes. The only changes allowed are the software clears of R6 and R9.
- R4: An event pulse is held inside the block and becomes visible in the status word on the cycle after the first `word_commit` that is sampled with `port_en` high. An event in the commit cycle itself is included in that commit.
- R5: At each enabled commit, every level flag (bits 15..12 and 3..0) takes the value of its source input. Between commits, level flags hold.
- R6: A receive overrun flag clears when a status read (`reg_rd` with `reg_addr`=0) is followed in a later cycle by `rx_data_acc` of that channel. A transmit underrun flag clears when a status read is followed by `tx_data_wr` of that channel.
- R7: A data-register access with no status read since the previous access of that channel leaves its error flag set. Each status read allows only one clearing access per channel.
- R8: If a clearing access falls in the same cycle as an enabled commit that carries a new error for the same flag, the flag stays set.
- R9: The frame-sync, last-slot and AC97 flags stay set until a status read, and they clear on the cycle after that read. A commit carrying a new such event in the read cycle keeps the flag set.
- R10: A bus write to address 0 does not change the status word.
- R11: The enable word sits at `reg_addr`=1 (bits 18..0 writable, 31..19 read zero). `irq` is high, in the same cycle, exactly when some status bit and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Serial port enable; flags update only while high |
| word_commit | input | 1 | Strobe: first bit of the next serial word completed |
| rx_fifo_full | input | 2 | Receive FIFO full level, per channel |
| tx_fifo_empty | input | 2 | Transmit FIFO empty level, per channel |
| rx_data_ready | input | 2 | Receive data ready level, per channel |
| tx_data_empty | input | 2 | Transmit data empty level, per channel |
| rx_overrun_ev | input | 2 | Receive overrun event pulse, per channel |
| tx_underrun_ev | input | 2 | Transmit underrun event pulse, per channel |
| tx_frame_ev | input | 1 | Transmit frame sync event |
| rx_frame_ev | input | 1 | Receive frame sync event |
| tx_last_ev | input | 1 | Transmit last time slot event |
| rx_last_ev | input | 1 | Receive last time slot event |
| cmd_addr_ev | input | 1 | AC97 command address updated event |
| cmd_data_ev | input | 1 | AC97 command data updated event |
| rx_tag_ev | input | 1 | AC97 receive tag updated event |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status word, 1 = enable word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| rx_data_acc | input | 2 | Receive data register access strobe, per channel |
| tx_data_wr | input | 2 | Transmit data register write strobe, per channel |
| irq | output | 1 | Combined masked interrupt |

## Verification
A clearing step and a commit step can fall in the same clock cycle. This happens when a data-register access meets a commit that carries a fresh overrun or underrun, and when a status read meets a commit that carries a new frame, slot or AC97 event. Directed steps force both cases: the clearing strobe and the commit with the new event are driven together, and the flag must still read as set on the following cycle. The random phase produces many more such collisions. Each one is judged against a bench model of the flag word that is updated from the requirements every cycle.

// File: rtl/sai_stat_pkg.sv
package sai_stat_pkg;
   localparam int STAT_W  = 19;
   localparam int NUM_ERR = 4;
   localparam int ERR_LO  = 8;
   // event-type (sticky) flags: 18..16 and 11..4
   localparam logic [STAT_W-1:0] STICKY_MASK = 19'h70FF0;
   // sticky flags that a plain status read clears
   localparam logic [STAT_W-1:0] MARKER_MASK = 19'h700F0;
   localparam logic [STAT_W-1:0] RESET_VAL   = 19'h03003;
endpackage

// File: rtl/sai_evt_capture.sv
module sai_evt_capture #(
   parameter int W = 19
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         capture_en,
   input  logic         commit,
   input  logic [W-1:0] ev_in,
   output logic [W-1:0] merged
);
   logic [W-1:0] pend_q;
   logic [W-1:0] ev_gated;

   assign ev_gated = capture_en ? ev_in : '0;
   assign merged   = pend_q | ev_gated;

   always_ff @(posedge clk) begin
      if (!rst_n)      pend_q <= '0;
      else if (commit) pend_q <= '0;
      else             pend_q <= pend_q | ev_gated;
   end
endmodule

// File: rtl/sai_err_clear.sv
module sai_err_clear #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         status_rd,
   input  logic [N-1:0] access,
   output logic [N-1:0] clr
);
   for (genvar i = 0; i < N; i++) begin : g_arm
      logic arm_q;
      assign clr[i] = arm_q & access[i];
      always_ff @(posedge clk) begin
         if (!rst_n) arm_q <= 1'b0;
         else        arm_q <= (arm_q & ~access[i]) | status_rd;
      end
   end
endmodule

// File: rtl/sai_stat_bits.sv
module sai_stat_bits #(
   parameter int           W      = 19,
   parameter logic [W-1:0] STICKY = '0,
   parameter logic [W-1:0] RST    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         commit,
   input  logic [W-1:0] lvl_src,
   input  logic [W-1:0] set_src,
   input  logic [W-1:0] clr,
   output logic [W-1:0] stat_q
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic bit_q;
      logic bit_d;
      assign stat_q[i] = bit_q;
      if (STICKY[i]) begin : g_evt
         logic unused_lvl;
         assign unused_lvl = lvl_src[i];
         assign bit_d = (bit_q & ~clr[i]) | (commit & set_src[i]);
      end else begin : g_lvl
         logic unused_evt;
         assign unused_evt = set_src[i] | clr[i];
         assign bit_d = commit ? lvl_src[i] : bit_q;
      end
      always_ff @(posedge clk) begin
         if (!rst_n) bit_q <= RST[i];
         else        bit_q <= bit_d;
      end
   end
endmodule

// File: rtl/sai_irq_mask.sv
module sai_irq_mask #(
   parameter int W = 19
) (
   input  logic [W-1:0] stat,
   input  logic [W-1:0] enable,
   output logic         irq
);
   assign irq = |(stat & enable);
endmodule

// File: rtl/sai_irq_status.sv
module sai_irq_status
   import sai_stat_pkg::*;
#(
   parameter int REG_W  = 32,
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              word_commit,
   input  logic [NUM_CH-1:0] rx_fifo_full,
   input  logic [NUM_CH-1:0] tx_fifo_empty,
   input  logic [NUM_CH-1:0] rx_data_ready,
   input  logic [NUM_CH-1:0] tx_data_empty,
   input  logic [NUM_CH-1:0] rx_overrun_ev,
   input  logic [NUM_CH-1:0] tx_underrun_ev,
   input  logic              tx_frame_ev,
   input  logic              rx_frame_ev,
   input  logic              tx_last_ev,
   input  logic              rx_last_ev,
   input  logic              cmd_addr_ev,
   input  logic              cmd_data_ev,
   input  logic              rx_tag_ev,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [NUM_CH-1:0] rx_data_acc,
   input  logic [NUM_CH-1:0] tx_data_wr,
   output logic              irq
);
   localparam int PAD_W = REG_W - STAT_W;

   if (NUM_CH != 2) begin : g_bad_ch
      $error("sai_irq_status: the flag layout holds exactly two channels");
   end
   if (REG_W <= STAT_W) begin : g_bad_w
      $error("sai_irq_status: register width must exceed the flag count");
   end

   logic [STAT_W-1:0]  status_q;
   logic [STAT_W-1:0]  ien_q;
   logic [STAT_W-1:0]  ev_vec;
   logic [STAT_W-1:0]  lvl_vec;
   logic [STAT_W-1:0]  merged;
   logic [STAT_W-1:0]  clr_vec;
   logic [NUM_ERR-1:0] err_acc;
   logic [NUM_ERR-1:0] err_clr;
   logic               commit_now;
   logic               status_rd;
   logic               unused_wdata;

   assign commit_now   = port_en & word_commit;
   assign status_rd    = reg_rd & ~reg_addr;
   assign unused_wdata = ^reg_wdata[REG_W-1:STAT_W];

   assign ev_vec  = {cmd_addr_ev, cmd_data_ev, rx_tag_ev, 4'b0000,
                     rx_overrun_ev, tx_underrun_ev,
                     tx_frame_ev, rx_frame_ev, tx_last_ev, rx_last_ev, 4'b0000};
   assign lvl_vec = {3'b000, rx_data_ready, tx_data_empty, 8'h00,
                     rx_fifo_full, tx_fifo_empty};
   assign err_acc = {rx_data_acc, tx_data_wr};

   always_comb begin
      clr_vec = MARKER_MASK & {STAT_W{status_rd}};
      clr_vec[ERR_LO +: NUM_ERR] = err_clr;
   end

   sai_evt_capture #(.W(STAT_W)) u_capture (
      .clk(clk), .rst_n(rst_n), .capture_en(port_en), .commit(commit_now),
      .ev_in(ev_vec), .merged(merged)
   );

   sai_err_clear #(.N(NUM_ERR)) u_errclr (
      .clk(clk), .rst_n(rst_n), .status_rd(status_rd),
      .access(err_acc), .clr(err_clr)
   );

   sai_stat_bits #(.W(STAT_W), .STICKY(STICKY_MASK), .RST(RESET_VAL)) u_bits (
      .clk(clk), .rst_n(rst_n), .commit(commit_now), .lvl_src(lvl_vec),
      .set_src(merged), .clr(clr_vec), .stat_q(status_q)
   );

   sai_irq_mask #(.W(STAT_W)) u_irq (
      .stat(status_q), .enable(ien_q), .irq(irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                  ien_q <= '0;
      else if (reg_wr && reg_addr) ien_q <= reg_wdata[STAT_W-1:0];
   end

   assign reg_rdata = reg_addr ? {{PAD_W{1'b0}}, ien_q} : {{PAD_W{1'b0}}, status_q};
endmodule

// File: rtl/sai_irq_status_chk.sv
module sai_irq_status_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        port_en,
   input logic        word_commit,
   input logic        reg_rd,
   input logic        reg_addr,
   input logic [1:0]  rx_data_acc,
   input logic [1:0]  tx_data_wr,
   input logic [12:0] rdata_hi,
   input logic        irq,
   input logic [18:0] status_q,
   input logic [18:0] ien_q
);
   // R1
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_hi == 13'd0);

   // R3
   hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_en && !reg_rd && rx_data_acc == 2'b00 && tx_data_wr == 2'b00)
      |=> $stable(status_q));

   // R5
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(port_en && word_commit) |=> ($stable(status_q[15:12]) && $stable(status_q[3:0])));

   // R6
   rx_err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_q[10]) |-> $past(rx_data_acc[0]));

   // R6
   tx_err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_q[9]) |-> $past(tx_data_wr[1]));

   // R9
   marker_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_q[5]) |-> $past(reg_rd && !reg_addr));

   // R11
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == 19'd0) |-> !irq);
endmodule

bind sai_irq_status sai_irq_status_chk u_chk (
   .clk(clk), .rst_n(rst_n), .port_en(port_en), .word_commit(word_commit),
   .reg_rd(reg_rd), .reg_addr(reg_addr), .rx_data_acc(rx_data_acc),
   .tx_data_wr(tx_data_wr), .rdata_hi(reg_rdata[31:19]), .irq(irq),
   .status_q(status_q), .ien_q(ien_q)
);

// File: tb/sai_irq_status_test.sv
module sai_irq_status_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        port_en, word_commit;
   logic [1:0]  rx_fifo_full, tx_fifo_empty, rx_data_ready, tx_data_empty;
   logic [1:0]  rx_overrun_ev, tx_underrun_ev;
   logic        tx_frame_ev, rx_frame_ev, tx_last_ev, rx_last_ev;
   logic        cmd_addr_ev, cmd_data_ev, rx_tag_ev;
   logic        reg_rd, reg_wr, reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic [1:0]  rx_data_acc, tx_data_wr;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   // bench model of the flag word
   logic [18:0] m_stat, m_pend, m_ien;
   logic [3:0]  m_arm;

   localparam logic [18:0] LVL_M = 19'h0F00F;
   localparam logic [18:0] ERR_M = 19'h00F00;
   localparam logic [18:0] MRK_M = 19'h700F0;

   always #10 clk = ~clk;

   sai_irq_status uut (.*);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   function automatic logic [18:0] ev_now();
      ev_now = '0;
      ev_now[18] = cmd_addr_ev; ev_now[17] = cmd_data_ev; ev_now[16] = rx_tag_ev;
      ev_now[11:10] = rx_overrun_ev; ev_now[9:8] = tx_underrun_ev;
      ev_now[7] = tx_frame_ev; ev_now[6] = rx_frame_ev;
      ev_now[5] = tx_last_ev;  ev_now[4] = rx_last_ev;
   endfunction

   function automatic logic [18:0] lvl_now();
      lvl_now = '0;
      lvl_now[15:14] = rx_data_ready; lvl_now[13:12] = tx_data_empty;
      lvl_now[3:2]   = rx_fifo_full;  lvl_now[1:0]   = tx_fifo_empty;
   endfunction

   task automatic model_update();
      logic [18:0] evg, mrg, clr, nxt;
      logic [3:0]  acc;
      logic        cm, rd;
      cm  = port_en & word_commit;
      rd  = reg_rd & ~reg_addr;
      evg = port_en ? ev_now() : '0;
      mrg = m_pend | evg;
      acc = {rx_data_acc, tx_data_wr};
      clr = rd ? MRK_M : '0;
      clr[11:8] = m_arm & acc;
      nxt = cm ? (lvl_now() & LVL_M) : (m_stat & LVL_M);
      nxt = nxt | (m_stat & ~LVL_M & ~clr) | (cm ? (mrg & ~LVL_M) : '0);
      m_stat = nxt;
      m_pend = cm ? '0 : mrg;
      m_arm  = (m_arm & ~acc) | {4{rd}};
      if (reg_wr && reg_addr) m_ien = reg_wdata[18:0];
   endtask

   task automatic check_outputs();
      logic [31:0] e;
      if (!reg_addr) begin
         e = {13'd0, m_stat};
         chk(reg_rdata[31:19] == 13'd0, "R1 reserved", reg_rdata, e);
         chk((reg_rdata[18:0] & LVL_M) == (m_stat & LVL_M), "R5 level flags", reg_rdata, e);
         chk((reg_rdata[18:0] & ERR_M) == (m_stat & ERR_M), "R6 error flags", reg_rdata, e);
         chk((reg_rdata[18:0] & MRK_M) == (m_stat & MRK_M), "R9 marker flags", reg_rdata, e);
      end else begin
         chk(reg_rdata == {13'd0, m_ien}, "R11 enable readback", reg_rdata, {13'd0, m_ien});
      end
      chk(irq == |(m_stat & m_ien), "R11 irq", {31'd0, irq}, {31'd0, |(m_stat & m_ien)});
   endtask

   task automatic step();
      #1 check_outputs();
      @(posedge clk);
      if (rst_n) model_update();
      @(negedge clk);
   endtask

   task automatic clear_in();
      port_en = 1'b1; word_commit = 1'b0;
      rx_fifo_full = '0; tx_fifo_empty = '0; rx_data_ready = '0; tx_data_empty = '0;
      rx_overrun_ev = '0; tx_underrun_ev = '0;
      tx_frame_ev = 0; rx_frame_ev = 0; tx_last_ev = 0; rx_last_ev = 0;
      cmd_addr_ev = 0; cmd_data_ev = 0; rx_tag_ev = 0;
      reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = '0;
      rx_data_acc = '0; tx_data_wr = '0;
   endtask

   task automatic expect_stat(input logic [18:0] exp, input string tag);
      #1 chk(reg_rdata == {13'd0, exp}, tag, reg_rdata, {13'd0, exp});
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      clear_in();
      rst_n = 1'b0;
      m_stat = 19'h03003; m_pend = '0; m_ien = '0; m_arm = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      expect_stat(19'h03003, "R2 reset status");
      reg_addr = 1; #1 chk(reg_rdata == 32'd0, "R2 reset enable", reg_rdata, 32'd0);
      clear_in();

      // R3: disabled port ignores commit, levels and events
      port_en = 0; word_commit = 1; rx_fifo_full = 2'b11; rx_data_ready = 2'b11;
      rx_overrun_ev = 2'b11; tx_last_ev = 1; cmd_addr_ev = 1;
      step(); clear_in();
      expect_stat(19'h03003, "R3 disabled hold");

      // R4: event held until commit
      rx_overrun_ev = 2'b01; step(); clear_in();
      expect_stat(19'h03003, "R4 not before commit");
      word_commit = 1; step(); clear_in();
      expect_stat(19'h00400, "R4 visible after commit");

      // R5: levels sampled at commit, held between
      word_commit = 1; rx_data_ready = 2'b10; tx_fifo_empty = 2'b01; step(); clear_in();
      expect_stat(19'h08401, "R5 level sample");
      rx_data_ready = 2'b01; step(); clear_in();
      expect_stat(19'h08401, "R5 level hold");

      // R7: access without status read
      rx_data_acc = 2'b01; step(); clear_in();
      expect_stat(19'h08401, "R7 no read no clear");

      // R6: read then access
      reg_rd = 1; step(); clear_in();
      rx_data_acc = 2'b01; step(); clear_in();
      expect_stat(19'h08001, "R6 receive clear");

      // R8: clear and new error in the same cycle
      word_commit = 1; tx_underrun_ev = 2'b10; step(); clear_in();
      expect_stat(19'h00200, "R8 setup");
      reg_rd = 1; step(); clear_in();
      tx_data_wr = 2'b10; word_commit = 1; tx_underrun_ev = 2'b10; step(); clear_in();
      expect_stat(19'h00200, "R8 set wins");
      tx_data_wr = 2'b10; step(); clear_in();
      expect_stat(19'h00200, "R7 arm consumed");
      reg_rd = 1; step(); clear_in();
      tx_data_wr = 2'b10; step(); clear_in();
      expect_stat(19'h00000, "R6 transmit clear");

      // R10: write to status address
      reg_wr = 1; reg_wdata = 32'hFFFF_FFFF; step(); clear_in();
      expect_stat(19'h00000, "R10 write ignored");

      // R9: marker sticky, read clears, same-cycle commit wins
      word_commit = 1; tx_last_ev = 1; step(); clear_in();
      step();
      expect_stat(19'h00020, "R9 sticky");
      reg_rd = 1; step(); clear_in();
      expect_stat(19'h00000, "R9 read clears");
      reg_rd = 1; word_commit = 1; rx_frame_ev = 1; step(); clear_in();
      expect_stat(19'h00040, "R9 commit wins");
      reg_rd = 1; step(); clear_in();

      // R11: enable mask and irq
      word_commit = 1; tx_underrun_ev = 2'b01; reg_wr = 1; reg_addr = 1; reg_wdata = 32'h100;
      step(); clear_in();
      #1 chk(irq == 1'b1, "R11 irq on", {31'd0, irq}, 32'd1);
      reg_addr = 1; #1 chk(reg_rdata == 32'h100, "R11 enable read", reg_rdata, 32'h100);
      reg_wr = 1; reg_wdata = 32'h0FF; step(); clear_in();
      #1 chk(irq == 1'b0, "R11 irq masked", {31'd0, irq}, 32'd0);

      // random phase
      for (int n = 0; n < 5000; n++) begin
         port_en        = ($urandom % 8) != 0;
         word_commit    = ($urandom % 4) == 0;
         rx_fifo_full   = 2'($urandom); tx_fifo_empty = 2'($urandom);
         rx_data_ready  = 2'($urandom); tx_data_empty = 2'($urandom);
         rx_overrun_ev  = {($urandom % 6) == 0, ($urandom % 6) == 0};
         tx_underrun_ev = {($urandom % 6) == 0, ($urandom % 6) == 0};
         tx_frame_ev    = ($urandom % 6) == 0; rx_frame_ev = ($urandom % 6) == 0;
         tx_last_ev     = ($urandom % 6) == 0; rx_last_ev  = ($urandom % 6) == 0;
         cmd_addr_ev    = ($urandom % 6) == 0; cmd_data_ev = ($urandom % 6) == 0;
         rx_tag_ev      = ($urandom % 6) == 0;
         reg_addr       = ($urandom % 5) == 0;
         reg_rd         = ($urandom % 5) == 0;
         reg_wr         = ($urandom % 10) == 0;
         reg_wdata      = $urandom;
         rx_data_acc    = {($urandom % 5) == 0, ($urandom % 5) == 0};
         tx_data_wr     = {($urandom % 5) == 0, ($urandom % 5) == 0};
         step();
      end
      clear_in();
      step();

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule